// File: doc/BRIEF.md
# Temperature Compensation Update Scheduler

This block decides when the temperature-driven frequency correction of a timekeeping oscillator is refreshed. It owns an 8-bit control register that holds a master enable, a two-bit policy for running from the backup battery, and a 5-bit factory calibration field that software cannot alter. A 1 Hz tick drives an interval timer. The interval is 60 seconds on main power. On battery the interval is 60 seconds or 10 minutes, or the timer is off, depending on the policy. A write that sets the enable also starts a cycle straight away.

Each cycle asks an external sensor for a conversion and holds the request until the sensor answers with a reading. The block then presents that reading to an external lookup, which returns one fine and one coarse correction value. The final trim registers take the looked-up pair only when the reading differs from the one last committed. A trigger that arrives while a cycle is running is remembered, and one more cycle follows.

Top module: `tcomp_sched`

## Requirements
- R1: After reset, the register reads back as the calibration value in bits 4:0 with bits 7:5 clear. The final fine and coarse outputs are zero and no conversion is requested.
- R2: A register write stores bits 7 (enable), 6:5 (battery policy) and ignores bits 4:0, which always read back as the calibration parameter (default 5'h13).
- R3: A write with bit 7 set raises the conversion request on the next clock and restarts the interval count from zero.
- R4: On main power with the enable set, a request is raised on the tick that completes 60 ticks since the last cycle start, and not before.
- R5: On battery the policy in bits 6:5 sets the timer: 00 means no timed requests, 01 means every 60 ticks, and 10 or 11 mean every 600 ticks.
- R6: The conversion request stays high until the done strobe is seen, and the reading is taken in that same cycle.
- R7: The lookup address output carries the captured reading. The first completed conversion after reset always loads the looked-up pair into the final outputs.
- R8: A completed conversion whose reading equals the last committed reading leaves both final outputs unchanged, even if the lookup values differ.
- R9: Any number of triggers during a running cycle yield exactly one further cycle, which starts right after the current one commits.
- R10: A write with bit 7 clear starts no cycle, stops the interval timer and keeps the final outputs at their last committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| on_battery | input | 1 | High while running from the backup battery |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| conv_req | output | 1 | Temperature conversion request |
| conv_done | input | 1 | Conversion finished, reading valid |
| conv_temp | input | TEMP_W | Temperature reading |
| lut_temp | output | TEMP_W | Lookup address: captured reading |
| lut_fine | input | FINE_W | Looked-up fine correction |
| lut_coarse | input | COARSE_W | Looked-up coarse correction |
| final_fine | output | FINE_W | Committed fine trim |
| final_coarse | output | COARSE_W | Committed coarse trim |

## Verification
Readings are drawn at random from a set of only four values, so repeated and changed readings both occur often. The lookup offset is reshuffled every cycle, which means a wrongly committed repeat shows up as changed outputs. Tick trains of exactly one short of the interval and then the full interval are run for main power and for each battery policy, which separates the 60 and 600 tick paths and the off setting. Back-to-back writes during a running cycle show whether extra triggers are merged into one, lost, or duplicated.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CONV   = 2'd1,
      ST_COMMIT = 2'd2
   } tcs_state_e;

   localparam int unsigned CTRL_W   = 8;
   localparam int unsigned EN_BIT   = 7;
   localparam int unsigned POL_HI   = 6;
   localparam int unsigned POL_LO   = 5;
   localparam int unsigned CAL_W    = 5;

   localparam logic [1:0] POL_OFF   = 2'b00;
   localparam logic [1:0] POL_SHORT = 2'b01;
   localparam logic [1:0] POL_LONG  = 2'b10;
   localparam logic [1:0] POL_LONG2 = 2'b11;
endpackage

// File: rtl/tcs_ctrl_reg.sv
module tcs_ctrl_reg
   import tcs_pkg::*;
#(
   parameter logic [CAL_W-1:0] CAL_VALUE = 5'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] rdata,
   output logic              en,
   output logic [1:0]        policy,
   output logic              wr_start,
   output logic              wr_stop
);
   logic       en_q;
   logic [1:0] pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pol_q <= POL_OFF;
      end else if (wr) begin
         en_q  <= wdata[EN_BIT];
         pol_q <= wdata[POL_HI:POL_LO];
      end
   end

   assign en       = en_q;
   assign policy   = pol_q;
   assign rdata    = {en_q, pol_q, CAL_VALUE};
   assign wr_start = wr &&  wdata[EN_BIT];
   assign wr_stop  = wr && !wdata[EN_BIT];

   AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata[CTRL_W-1:CAL_W] == $past(wdata[CTRL_W-1:CAL_W]))); // R2
endmodule

// File: rtl/tcs_interval_timer.sv
module tcs_interval_timer
   import tcs_pkg::*;
#(
   parameter int unsigned SHORT_SEC   = 60,
   parameter int unsigned LONG_SEC    = 600,
   parameter bit          POL11_LONG  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] policy,
   input  logic       on_battery,
   input  logic       tick,
   input  logic       restart,
   output logic       fire
);
   localparam int unsigned CNT_W = $clog2(LONG_SEC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             long_sel;
   logic             active;
   logic [CNT_W:0]   cnt_nxt;

   generate
      if (POL11_LONG) begin : g_pol11_long
         assign long_sel = on_battery && policy[1];
      end else begin : g_pol11_short
         assign long_sel = on_battery && (policy == POL_LONG);
      end
   endgenerate

   assign active  = en && (!on_battery || (policy != POL_OFF));
   assign limit   = long_sel ? CNT_W'(LONG_SEC) : CNT_W'(SHORT_SEC);
   assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
   assign fire    = active && !restart && tick && (cnt_nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!active || restart) cnt_q <= '0;
      else if (tick) begin
         if (cnt_nxt >= {1'b0, limit}) cnt_q <= '0;
         else                          cnt_q <= cnt_nxt[CNT_W-1:0];
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(LONG_SEC)); // R5
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/tcs_sequencer.sv
module tcs_sequencer
   import tcs_pkg::*;
#(
   parameter int unsigned TEMP_W   = 8,
   parameter int unsigned FINE_W   = 6,
   parameter int unsigned COARSE_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic                drop_pend,
   output logic                conv_req,
   input  logic                conv_done,
   input  logic [TEMP_W-1:0]   conv_temp,
   output logic [TEMP_W-1:0]   lut_temp,
   input  logic [FINE_W-1:0]   lut_fine,
   input  logic [COARSE_W-1:0] lut_coarse,
   output logic [FINE_W-1:0]   final_fine,
   output logic [COARSE_W-1:0] final_coarse
);
   tcs_state_e          state_q;
   logic                pend_q;
   logic                valid_q;
   logic [TEMP_W-1:0]   tcap_q;
   logic [TEMP_W-1:0]   last_q;
   logic [FINE_W-1:0]   ff_q;
   logic [COARSE_W-1:0] fc_q;
   logic                changed;

   assign changed = !valid_q || (tcap_q != last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         tcap_q  <= '0;
         last_q  <= '0;
         ff_q    <= '0;
         fc_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (trig || (pend_q && !drop_pend)) state_q <= ST_CONV;
               pend_q <= 1'b0;
            end
            ST_CONV: begin
               if (trig)           pend_q <= 1'b1;
               else if (drop_pend) pend_q <= 1'b0;
               if (conv_done) begin
                  tcap_q  <= conv_temp;
                  state_q <= ST_COMMIT;
               end
            end
            ST_COMMIT: begin
               if (changed) begin
                  ff_q    <= lut_fine;
                  fc_q    <= lut_coarse;
                  last_q  <= tcap_q;
                  valid_q <= 1'b1;
               end
               state_q <= (trig || (pend_q && !drop_pend)) ? ST_CONV : ST_IDLE;
               pend_q  <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign conv_req     = (state_q == ST_CONV);
   assign lut_temp     = tcap_q;
   assign final_fine   = ff_q;
   assign final_coarse = fc_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> conv_req); // R6
   AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && state_q == ST_IDLE) |=> conv_req); // R3
   AST_SAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COMMIT && valid_q && tcap_q == last_q)
      |=> ($stable(final_fine) && $stable(final_coarse))); // R8
   AST_ONE_MORE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COMMIT && pend_q && !drop_pend) |=> conv_req); // R9
endmodule

// File: rtl/tcomp_sched.sv
module tcomp_sched
   import tcs_pkg::*;
#(
   parameter int unsigned      TEMP_W     = 8,
   parameter int unsigned      FINE_W     = 6,
   parameter int unsigned      COARSE_W   = 5,
   parameter int unsigned      SHORT_SEC  = 60,
   parameter int unsigned      LONG_SEC   = 600,
   parameter bit               POL11_LONG = 1'b1,
   parameter logic [4:0]       CAL_VALUE  = 5'h13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic                on_battery,
   input  logic                tick_1hz,
   output logic                conv_req,
   input  logic                conv_done,
   input  logic [TEMP_W-1:0]   conv_temp,
   output logic [TEMP_W-1:0]   lut_temp,
   input  logic [FINE_W-1:0]   lut_fine,
   input  logic [COARSE_W-1:0] lut_coarse,
   output logic [FINE_W-1:0]   final_fine,
   output logic [COARSE_W-1:0] final_coarse
);
   initial begin : param_chk
      if (SHORT_SEC < 1 || LONG_SEC < SHORT_SEC || TEMP_W < 1 ||
          FINE_W < 1 || COARSE_W < 1)
         $error("tcomp_sched: illegal parameter set");
   end

   logic       en;
   logic [1:0] policy;
   logic       wr_start;
   logic       wr_stop;
   logic       fire;
   logic       trig;

   tcs_ctrl_reg #(.CAL_VALUE(CAL_VALUE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .en(en), .policy(policy),
      .wr_start(wr_start), .wr_stop(wr_stop)
   );

   tcs_interval_timer #(
      .SHORT_SEC(SHORT_SEC), .LONG_SEC(LONG_SEC), .POL11_LONG(POL11_LONG)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .policy(policy),
      .on_battery(on_battery), .tick(tick_1hz), .restart(wr_start),
      .fire(fire)
   );

   assign trig = wr_start || (fire && !wr_stop);

   tcs_sequencer #(
      .TEMP_W(TEMP_W), .FINE_W(FINE_W), .COARSE_W(COARSE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .drop_pend(wr_stop),
      .conv_req(conv_req), .conv_done(conv_done), .conv_temp(conv_temp),
      .lut_temp(lut_temp), .lut_fine(lut_fine), .lut_coarse(lut_coarse),
      .final_fine(final_fine), .final_coarse(final_coarse)
   );

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[7] && !conv_req) |=> !conv_req); // R10
endmodule

// File: tb/tb_tcomp_sched.sv
module tb_tcomp_sched;
   localparam int TW = 8, FW = 6, CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          on_battery = 1'b0;
   logic          tick_1hz = 1'b0;
   logic          conv_req;
   logic          conv_done = 1'b0;
   logic [TW-1:0] conv_temp = '0;
   logic [TW-1:0] lut_temp;
   logic [FW-1:0] lut_fine;
   logic [CW-1:0] lut_coarse;
   logic [FW-1:0] final_fine;
   logic [CW-1:0] final_coarse;

   int   n_chk = 0, n_err = 0;
   bit   finished = 1'b0;
   logic [7:0] off = '0;
   bit   m_valid = 1'b0;
   logic [TW-1:0] m_last = '0;
   logic [FW-1:0] e_fine = '0;
   logic [CW-1:0] e_coarse = '0;

   always #4 clk = ~clk;

   function automatic logic [FW-1:0] f_fine(logic [TW-1:0] t, logic [7:0] o);
      return FW'((t * 3) + o);
   endfunction
   function automatic logic [CW-1:0] f_coarse(logic [TW-1:0] t, logic [7:0] o);
      return CW'(t ^ o);
   endfunction

   assign lut_fine   = f_fine(lut_temp, off);
   assign lut_coarse = f_coarse(lut_temp, off);

   tcomp_sched dut (.*);

   task automatic chk(string req, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic serve(logic [TW-1:0] t, string req);
      for (int i = 0; i < 20; i++) begin
         if (conv_req) break;
         @(negedge clk);
      end
      chk({req, " R6 request pending"}, conv_req, 1);
      conv_done = 1'b1; conv_temp = t;
      @(negedge clk);
      conv_done = 1'b0;
      chk({req, " R7 lookup address"}, lut_temp, t);
      @(negedge clk);
      if (!m_valid || t != m_last) begin
         e_fine = f_fine(t, off); e_coarse = f_coarse(t, off);
         m_last = t; m_valid = 1'b1;
      end
      chk({req, " R8 final fine"}, final_fine, e_fine);
      chk({req, " R8 final coarse"}, final_coarse, e_coarse);
   endtask

   task automatic ticks(int n, output int seen);
      seen = 0;
      for (int i = 0; i < n; i++) begin
         tick_1hz = 1'b1;
         @(negedge clk);
         tick_1hz = 1'b0;
         if (conv_req) seen++;
         @(negedge clk);
      end
   endtask

   task automatic period(int iv, string req);
      int seen;
      ticks(iv - 1, seen);
      chk({req, " no early request"}, seen, 0);
      ticks(1, seen);
      chk({req, " request at interval"}, seen, 1);
      serve(TW'(iv % 4), req);
   endtask

   initial begin
      int seen;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata", reg_rdata, 8'h13);
      chk("R1 fine", final_fine, 0);
      chk("R1 coarse", final_coarse, 0);
      chk("R1 req", conv_req, 0);

      wr(8'h7F);
      chk("R2 rdata keeps cal", reg_rdata, 8'h73);
      chk("R10 no start with enable clear", conv_req, 0);

      wr(8'h80);
      chk("R3 request next clock", conv_req, 1);
      serve(8'd5, "R7 first commit");

      off = 8'd9;
      wr(8'h80);
      serve(8'd5, "R8 same reading");
      serve_changed: begin
         wr(8'h80);
         serve(8'd6, "R8 new reading");
      end

      wr(8'h80);
      wr(8'h80);
      wr(8'h80);
      serve(8'd7, "R9 first");
      chk("R9 one more cycle", conv_req, 1);
      serve(8'd7, "R9 second");
      @(negedge clk);
      chk("R9 only one more", conv_req, 0);

      wr(8'h80);
      serve(8'd1, "R3 restart");
      period(60, "R4 main power");

      on_battery = 1'b1;
      wr(8'h80);
      serve(8'd2, "R5 pol00");
      ticks(700, seen);
      chk("R5 pol00 no timed request", seen, 0);
      wr(8'hA0);
      serve(8'd3, "R5 pol01");
      period(60, "R5 pol01");
      wr(8'hC0);
      serve(8'd1, "R5 pol10");
      period(600, "R5 pol10");
      wr(8'hE0);
      serve(8'd2, "R5 pol11");
      period(600, "R5 pol11");
      on_battery = 1'b0;

      wr(8'h00);
      chk("R10 no start", conv_req, 0);
      off = 8'd33;
      ticks(130, seen);
      chk("R10 timer stopped", seen, 0);
      chk("R10 fine kept", final_fine, e_fine);
      chk("R10 coarse kept", final_coarse, e_coarse);
      chk("R10 rdata", reg_rdata, 8'h13);

      for (int k = 0; k < 40; k++) begin
         off = 8'($urandom % 64);
         wr(8'h80 | 8'($urandom % 4) << 5);
         serve(TW'($urandom % 4), "R8 random");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got hang expected finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule